// File: doc/BRIEF.md
# Memory Request Address Router

This block sits between a processor and the memories and buses behind it. Each memory request carries a 32-bit address in a 4 GB space. The block classifies the request and drives a one-hot target select that names exactly one destination: main RAM, the PCI/MMIO bus, the interrupt-controller window, the boot flash window, or a system-management segment. The system-management segment is a high window that is remapped onto low RAM. The block also returns the address the chosen target should see. The result is registered, so it appears one cycle after the request.

The boundary between RAM and the PCI/MMIO bus is not fixed. It follows a top-of-memory value written through a small configuration port in units of 8 MB. That value is capped at 512 MB, the largest amount of RAM the system can hold. Two fixed high windows always take priority over the RAM/PCI split and are never sent to PCI. One more high window is answered from low RAM, but only while the processor reports that it is in system management mode. Outside that mode, the same addresses fall through to PCI like any other MMIO access.

Top module: `addr_route_core`

## Requirements
- R1: After reset, `out_valid` is 0, `out_tgt` is 0, and the top-of-memory value is 0, so a request to address 0000_0000h is sent to PCI.
- R2: A request whose address is below the top of memory (value × 8 MB) selects RAM (`out_tgt` bit 0) with `out_addr` equal to the request address.
- R3: A request at or above the top of memory that falls in no fixed or system-management window selects PCI (`out_tgt` bit 1) with `out_addr` equal to the request address.
- R4: A write on the configuration port (`cfg_wr`=1) loads the top of memory from `cfg_wdata` in 8 MB units; a value above 64 is stored as 64 (512 MB).
- R5: Addresses FEC0_0000h–FEC0_0FFFh select the interrupt-controller target (`out_tgt` bit 2) with the address unchanged, whatever the top of memory and the mode flag.
- R6: Addresses FFF0_0000h–FFFF_FFFFh select the boot flash target (`out_tgt` bit 3) with the address unchanged.
- R7: With `smm_active`=1, addresses FEEA_0000h–FEEB_FFFFh select the system-management RAM target (`out_tgt` bit 4) with `out_addr` = address − FEEA_0000h + 000A_0000h.
- R8: With `smm_active`=0, addresses FEEA_0000h–FEEB_FFFFh select PCI with the address unchanged.
- R9: The outputs follow the request by exactly one clock: `out_valid` equals the previous cycle's `req_valid`, `out_write` echoes `req_write`, exactly one `out_tgt` bit is set when `out_valid` is 1, and none is set otherwise.
- R10: A request presented in the same cycle as a configuration write is decoded with the top of memory in force before that write; the new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| smm_active | input | 1 | Processor is in system management mode |
| cfg_wr | input | 1 | Load the top-of-memory register |
| cfg_wdata | input | 8 | Top of memory in 8 MB units |
| out_valid | output | 1 | Decoded request present |
| out_tgt | output | 5 | One-hot target: 0 RAM, 1 PCI, 2 interrupt controller, 3 flash, 4 SMM RAM |
| out_addr | output | 32 | Address presented to the target |
| out_write | output | 1 | Write strobe of the decoded request |

## Verification
Two functions can fall in the same cycle: a request's decode and a configuration write that moves the RAM/PCI boundary. The bench provokes this by issuing a write to top of memory together with a request that lies on the side of the boundary that changes. It then issues the same address again on the next cycle. The behavioural model in the bench applies the old boundary to the first request and the new boundary to the second. The DUT outputs are compared against this model every cycle. A second overlap, the mode flag changing between back-to-back requests to the system-management window, is judged the same way.

// File: rtl/addr_route_core.sv
module addr_route_core #(
  parameter int          GRAN_LG2 = 23,
  parameter int          CFG_W    = 8,
  parameter int          TOM_W    = 7,
  parameter int          TOM_MAX  = 64,
  parameter logic [31:0] IRQ_LO   = 32'hFEC0_0000,
  parameter logic [31:0] IRQ_HI   = 32'hFEC0_0FFF,
  parameter logic [31:0] ROM_LO   = 32'hFFF0_0000,
  parameter logic [31:0] SEG_LO   = 32'hFEEA_0000,
  parameter logic [31:0] SEG_HI   = 32'hFEEB_FFFF,
  parameter logic [31:0] SEG_DST  = 32'h000A_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              smm_active,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              out_valid,
  output logic [4:0]        out_tgt,
  output logic [31:0]       out_addr,
  output logic              out_write
);
  localparam int T_RAM = 0;
  localparam int T_PCI = 1;
  localparam int T_IRQ = 2;
  localparam int T_ROM = 3;
  localparam int T_SEG = 4;

  logic [TOM_W-1:0] tom_q;
  logic [32:0]      tom_lim;
  logic             hit_seg, hit_irq, hit_rom, hit_ram;
  logic [4:0]       tgt_d;
  logic [31:0]      addr_d;

  assign tom_lim = 33'(tom_q) << GRAN_LG2;
  assign hit_seg = smm_active && req_addr >= SEG_LO && req_addr <= SEG_HI;
  assign hit_irq = req_addr >= IRQ_LO && req_addr <= IRQ_HI;
  assign hit_rom = req_addr >= ROM_LO;
  assign hit_ram = {1'b0, req_addr} < tom_lim;

  always_comb begin
    tgt_d  = '0;
    addr_d = req_addr;
    if (hit_seg) begin
      tgt_d[T_SEG] = 1'b1;
      addr_d       = req_addr - SEG_LO + SEG_DST;
    end else if (hit_irq) tgt_d[T_IRQ] = 1'b1;
    else if (hit_rom)     tgt_d[T_ROM] = 1'b1;
    else if (hit_ram)     tgt_d[T_RAM] = 1'b1;
    else                  tgt_d[T_PCI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tom_q <= '0;
    else if (cfg_wr)
      tom_q <= (cfg_wdata > CFG_W'(TOM_MAX)) ? TOM_W'(TOM_MAX) : TOM_W'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tgt   <= '0;
      out_addr  <= '0;
      out_write <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_tgt   <= req_valid ? tgt_d : 5'b0;
      out_addr  <= addr_d;
      out_write <= req_valid && req_write;
    end
  end
endmodule

// File: rtl/addr_route_chk.sv
module addr_route_chk #(
  parameter int GRAN_LG2 = 23,
  parameter int TOM_W    = 7,
  parameter int TOM_MAX  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_addr,
  input logic             req_write,
  input logic             smm_active,
  input logic [TOM_W-1:0] tom_q,
  input logic             out_valid,
  input logic [4:0]       out_tgt,
  input logic [31:0]      out_addr,
  input logic             out_write
);
  AST_TOM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tom_q <= TOM_W'(TOM_MAX)); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R9
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_tgt == 5'b0); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_tgt) == 1); // R9
  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> out_write); // R9
  AST_SEG_NEEDS_SMM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tgt[4] |-> $past(smm_active)); // R7
  AST_FIXED_NOT_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr >= 32'hFEC0_0000 && req_addr <= 32'hFEC0_0FFF |=> !out_tgt[1]); // R5
  AST_RAM_BELOW_TOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tgt[0] |-> {1'b0, out_addr} < (33'($past(tom_q)) << GRAN_LG2)); // R2
endmodule

bind addr_route_core addr_route_chk #(
  .GRAN_LG2(GRAN_LG2), .TOM_W(TOM_W), .TOM_MAX(TOM_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .smm_active(smm_active), .tom_q(tom_q),
  .out_valid(out_valid), .out_tgt(out_tgt), .out_addr(out_addr), .out_write(out_write)
);

// File: tb/addr_route_core_tb_top.sv
module addr_route_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        smm_active = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        out_valid;
  logic [4:0]  out_tgt;
  logic [31:0] out_addr;
  logic        out_write;

  int checks = 0;
  int failures = 0;
  int model_tom = 0;
  bit have_exp = 0;
  bit e_valid, e_write;
  logic [4:0]  e_tgt;
  logic [31:0] e_addr;
  string e_tag;
  bit done = 0;

  always #4 clk = ~clk;

  addr_route_core dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .smm_active(smm_active), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_tgt(out_tgt),
    .out_addr(out_addr), .out_write(out_write)
  );

  function automatic void model(input logic [31:0] a, input bit smm, input int tom,
                                output logic [4:0] t, output logic [31:0] x);
    longint ua = longint'(a);
    x = a;
    if (smm && ua >= 64'hFEEA_0000 && ua <= 64'hFEEB_FFFF) begin
      t = 5'b10000;
      x = 32'(ua - 64'hFEEA_0000 + 64'h000A_0000);
    end else if (ua >= 64'hFEC0_0000 && ua <= 64'hFEC0_0FFF) t = 5'b00100;
    else if (ua >= 64'hFFF0_0000) t = 5'b01000;
    else if (ua < longint'(tom) * 8388608) t = 5'b00001;
    else t = 5'b00010;
  endfunction

  task automatic compare();
    if (!have_exp) return;
    checks++;
    if (out_valid !== e_valid || out_tgt !== e_tgt || out_write !== e_write ||
        (e_valid && out_addr !== e_addr)) begin
      failures++;
      $display("FAIL %s: got v=%0b tgt=%05b addr=%08h wr=%0b exp v=%0b tgt=%05b addr=%08h wr=%0b",
               e_tag, out_valid, out_tgt, out_addr, out_write,
               e_valid, e_tgt, e_addr, e_write);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit w, input bit smm,
                      input bit cw, input int cd, input string tag);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_write = w; smm_active = smm;
    cfg_wr = cw; cfg_wdata = 8'(cd);
    e_valid = v; e_write = v && w; e_tag = tag;
    if (v) model(a, smm, model_tom, e_tgt, e_addr);
    else begin e_tgt = 5'b0; e_addr = '0; end
    if (cw) model_tom = (cd > 64) ? 64 : cd;
    have_exp = 1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_tgt !== 5'b0) begin
      failures++;
      $display("FAIL R1 reset: got v=%0b tgt=%05b exp v=0 tgt=00000", out_valid, out_tgt);
    end
    step(1, 32'h0000_0000, 0, 0, 0, 0, "R1 tom0 to PCI");
    step(0, 32'h0, 0, 0, 0, 0, "R9 idle");
    step(1, 32'h0000_1000, 0, 0, 1, 32, "R10 old tom applies");
    step(1, 32'h0000_1000, 1, 0, 0, 0, "R10 new tom applies");
    step(1, 32'h0FFF_FFFF, 0, 0, 0, 0, "R2 last RAM byte");
    step(1, 32'h1000_0000, 1, 0, 0, 0, "R3 first PCI byte");
    step(1, 32'h1FFF_FFFF, 0, 0, 1, 200, "R4 before saturating write");
    step(1, 32'h1FFF_FFFF, 0, 0, 0, 0, "R4 saturated 512MB RAM");
    step(1, 32'h2000_0000, 0, 0, 0, 0, "R4 saturated PCI");
    step(1, 32'hFEBF_FFFF, 0, 0, 0, 0, "R3 below irq window");
    step(1, 32'hFEC0_0000, 1, 0, 0, 0, "R5 irq low");
    step(1, 32'hFEC0_0FFF, 0, 1, 0, 0, "R5 irq high smm");
    step(1, 32'hFEC0_1000, 0, 0, 0, 0, "R3 above irq window");
    step(1, 32'hFFEF_FFFF, 0, 0, 0, 0, "R3 below flash");
    step(1, 32'hFFF0_0000, 0, 0, 0, 0, "R6 flash low");
    step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, "R6 flash high");
    step(1, 32'hFEEA_0000, 0, 1, 0, 0, "R7 seg low");
    step(1, 32'hFEEB_FFFF, 1, 1, 0, 0, "R7 seg high");
    step(1, 32'hFEEB_FFFF, 0, 0, 0, 0, "R8 seg no smm");
    step(1, 32'hFEEA_0000, 0, 1, 0, 0, "R7 smm back on");
    step(1, 32'hFEEC_0000, 0, 1, 0, 0, "R3 above seg");
    step(1, 32'hFEE9_FFFF, 0, 1, 0, 0, "R3 below seg");
    step(1, 32'h000A_0000, 0, 1, 0, 0, "R2 low RAM in smm");
    step(1, 32'h0000_0040, 0, 0, 1, 0, "R10 before tom cleared");
    step(1, 32'h0000_0040, 0, 0, 0, 0, "R3 tom cleared");
    step(1, 32'h0080_0000, 0, 0, 1, 1, "R4 one granule pre");
    step(1, 32'h007F_FFFF, 0, 0, 0, 0, "R4 one granule RAM");
    step(1, 32'h0080_0000, 0, 0, 0, 0, "R4 one granule PCI");
    step(1, 32'h0, 0, 0, 1, 64, "R4 max exact");
    begin
      int unsigned lcg = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
        logic [31:0] a;
        lcg = lcg * 1664525 + 1013904223;
        a = lcg;
        if (lcg[3:0] == 0) a = {16'hFEEA + 16'(lcg[4]), a[15:0]};
        if (lcg[3:0] == 1) a = {20'hFEC00, a[11:0]};
        if (lcg[3:0] == 2) a = {4'h0, a[27:0]};
        step(lcg[5], a, lcg[6], lcg[7], lcg[11:8] == 0, int'(lcg[19:12]) % 80,
             "R9 mixed traffic");
      end
    end
    step(0, 32'h0, 0, 0, 0, 0, "R9 flush");
    step(0, 32'h0, 0, 0, 0, 0, "R9 flush");
    done = 1;
    summary();
    $finish;
  end
endmodule